// File: doc/BRIEF.md
# Dual Octal-SPI Port Router

This block sits between two octal-SPI controller instances and two external memory ports. A control register picks how the controllers reach the ports. Each controller can keep its own port, the two can trade ports, or both can share one port in turns while the other port stays quiet. The routing is combinational: clock, chip-select, data strobe, 8-bit data and their output enables pass from the chosen controller to its port. Input data and strobe from a port return only to the controller routed to it.

In the two shared modes an arbiter gives the port to one requesting controller at a time. A simultaneous request is settled round-robin. A grant stays in place until the owner's chip-select has been asserted and released. A programmable idle gap must then pass before the next grant. A chip-select override can redirect routed chip-selects to a fixed port line or to both lines. A decoder splits a fixed memory-mapped window into two regions, one per controller. The second region's size is set in 64 MiB units. Writes to the control register made while traffic is in flight are held and applied once the block is idle.

Top module: `octal_port_router`

## Requirements
- R1: The control register is at register address 0 and the routing mode is in bits [1:0]. Mode 00 is direct: controller 0 drives port 0 and controller 1 drives port 1, and each port's input data returns to the controller routed to it. After reset the control register reads 0, the split register (register address 1) reads 0, and both grant outputs are high.
- R2: Mode 10 is swapped: controller 0 drives port 1 and controller 1 drives port 0, and input data returns crosswise.
- R3: Modes 01 and 11 share one port: port 0 for 01 and port 1 for 11. Bit 0 set means shared. The unused port holds chip-select high and drives data and strobe outputs to 0 with their enables low.
- R4: Outside shared modes both grants stay high. In shared modes at most one grant is high, a grant goes only to a requester, and when both request at once the controller not served last wins. After reset controller 0 wins the first tie.
- R5: A grant is held while the owner's chip-select is low, and until it returns high after having been low. A grant whose owner withdraws its request without ever lowering chip-select is released.
- R6: Control bits [23:16] hold a gap value G. After a grant is released, no grant is issued for G+1 cycles.
- R7: Control bit 4 enables chip-select override, and bits [6:5] choose the target. Value 0 sends every routed chip-select to port line 0, value 1 sends it to line 1, and values 2 and 3 send it to both lines. Data routing is unchanged.
- R8: The window starts at 0x6000_0000 and spans four 64 MiB units. The split register's low 3 bits give the size of region 2 in units, clamped to 4. Region 2 is the top part of the window and region 1 is the rest. A valid address in region 1 gives mem_sel 01 and one in region 2 gives 10.
- R9: A valid address outside the window gives mem_err high and mem_sel 00.
- R10: A control write made while a grant, a gap, or (outside shared modes) a low chip-select is active is held pending. While pending, the register reads the old value and no new grant is issued. The pending value is applied once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 split |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_valid | input | 1 | Address lookup valid |
| mem_addr | input | 32 | Address to decode |
| mem_sel | output | 2 | Region hit, one-hot per controller |
| mem_err | output | 1 | Address outside the window |
| c_req | input | 2 | Controller port requests |
| c_gnt | output | 2 | Controller port grants |
| c_sck | input | 2 | Controller serial clocks |
| c_cs_n | input | 2 | Controller chip-selects, active low |
| c_dqs_o | input | 2 | Controller strobe outputs |
| c_dqs_oe | input | 2 | Controller strobe output enables |
| c_dqs_i | output | 2 | Strobe returned to controllers |
| c_dq_o | input | 16 | Controller data outputs, 8 bits each |
| c_dq_oe | input | 2 | Controller data output enables |
| c_dq_i | output | 16 | Data returned to controllers |
| p_sck | output | 2 | Port serial clocks |
| p_cs_n | output | 2 | Port chip-select lines, active low |
| p_dqs_o | output | 2 | Port strobe outputs |
| p_dqs_oe | output | 2 | Port strobe output enables |
| p_dqs_i | input | 2 | Port strobe inputs |
| p_dq_o | output | 16 | Port data outputs |
| p_dq_oe | output | 2 | Port data output enables |
| p_dq_i | input | 16 | Port data inputs |

## Verification
The hardest case to reach is a control write that lands while a shared-mode transaction is in progress. To reach it, the stimulus first takes a grant and pulls the owner's chip-select low, then issues the write. It then confirms that readback and grants still reflect the old mode. Only after releasing the chip-select and letting the gap expire does it expect the new mode. The gap itself is measured by counting grant-free cycles between one owner's release and the round-robin handover to the other controller, which is kept requesting throughout.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int CTRL_W      = 32;
  localparam int OVR_EN_BIT  = 4;
  localparam int OVR_SEL_LSB = 5;
  localparam int GAP_LSB     = 16;
  localparam int GAP_W       = 8;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h00FF_0073;

  typedef enum logic [1:0] {
    RM_DIRECT = 2'b00,
    RM_SHARE0 = 2'b01,
    RM_SWAP   = 2'b10,
    RM_SHARE1 = 2'b11
  } route_mode_e;
endpackage

// File: rtl/opr_regs.sv
module opr_regs
  import opr_pkg::*;
#(
  parameter int SPLIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              idle,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [SPLIT_W-1:0] split_q,
  output logic              pend_o,
  output logic [CTRL_W-1:0] rdata
);
  logic [CTRL_W-1:0]  ctrl_d, pend_q, pend_d;
  logic               pval_q, pval_d;
  logic [SPLIT_W-1:0] split_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    pend_d  = pend_q;
    pval_d  = pval_q;
    split_d = split_q;
    if (pval_q && idle) begin
      ctrl_d = pend_q;
      pval_d = 1'b0;
    end
    if (we && !addr) begin
      if (idle) begin
        ctrl_d = wdata & CTRL_MASK;
        pval_d = 1'b0;
      end else begin
        pend_d = wdata & CTRL_MASK;
        pval_d = 1'b1;
      end
    end
    if (we && addr) split_d = wdata[SPLIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pend_q  <= '0;
      pval_q  <= 1'b0;
      split_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
      pval_q  <= pval_d;
      split_q <= split_d;
    end
  end

  assign pend_o = pval_q;
  assign rdata  = addr ? {{(CTRL_W-SPLIT_W){1'b0}}, split_q} : ctrl_q;

  // R10: the live control word only moves on a cycle that was idle
  p_commit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(idle));
endmodule

// File: rtl/opr_arb.sv
module opr_arb
  import opr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared,
  input  logic             hold,
  input  logic [1:0]       req,
  input  logic [1:0]       cs_n,
  input  logic [GAP_W-1:0] gap,
  output logic [1:0]       gnt,
  output logic             own_v,
  output logic             own,
  output logic             busy
);
  logic             own_v_q, own_v_d, own_q, own_d;
  logic             seen_q, seen_d, last_q, last_d;
  logic             gap_q, gap_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             pick, gap_done;

  assign pick     = (req == 2'b11) ? ~last_q : req[1];
  assign gap_done = !gap_q || (cnt_q == '0);

  always_comb begin
    own_v_d = own_v_q;
    own_d   = own_q;
    seen_d  = seen_q;
    last_d  = last_q;
    gap_d   = gap_q;
    cnt_d   = cnt_q;
    if (!shared) begin
      own_v_d = 1'b0;
      seen_d  = 1'b0;
      gap_d   = 1'b0;
      cnt_d   = '0;
    end else if (own_v_q) begin
      if (!cs_n[own_q]) seen_d = 1'b1;
      if (cs_n[own_q] && (seen_q || !req[own_q])) begin
        own_v_d = 1'b0;
        seen_d  = 1'b0;
        gap_d   = 1'b1;
        cnt_d   = gap;
      end
    end else begin
      if (gap_q) begin
        if (cnt_q == '0) gap_d = 1'b0;
        else             cnt_d = cnt_q - 1'b1;
      end
      if (gap_done && !hold && (req != 2'b00)) begin
        own_v_d = 1'b1;
        own_d   = pick;
        last_d  = pick;
        gap_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v_q <= 1'b0;
      own_q   <= 1'b0;
      seen_q  <= 1'b0;
      last_q  <= 1'b1;
      gap_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      own_v_q <= own_v_d;
      own_q   <= own_d;
      seen_q  <= seen_d;
      last_q  <= last_d;
      gap_q   <= gap_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gnt   = !shared ? 2'b11 : (own_v_q ? (own_q ? 2'b10 : 2'b01) : 2'b00);
  assign own_v = own_v_q;
  assign own   = own_q;
  assign busy  = own_v_q | gap_q;

  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shared |-> $onehot0(gnt));
  p_grant0_to_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && $rose(gnt[0])) |-> $past(req[0]));
  p_grant1_to_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && $rose(gnt[1])) |-> $past(req[1]));
  p_hold_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && own_v_q && !cs_n[own_q]) |=> (own_v_q && $stable(own_q)));
  p_gap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && gap_q && cnt_q != '0) |=> (gnt == 2'b00));
endmodule

// File: rtl/opr_xbar.sv
module opr_xbar
  import opr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  route_mode_e   mode,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_sel,
  input  logic          own_v,
  input  logic          own,
  input  logic [1:0]    c_sck,
  input  logic [1:0]    c_cs_n,
  input  logic [1:0]    c_dqs_o,
  input  logic [1:0]    c_dqs_oe,
  output logic [1:0]    c_dqs_i,
  input  logic [2*DW-1:0] c_dq_o,
  input  logic [1:0]    c_dq_oe,
  output logic [2*DW-1:0] c_dq_i,
  output logic [1:0]    p_sck,
  output logic [1:0]    p_cs_n,
  output logic [1:0]    p_dqs_o,
  output logic [1:0]    p_dqs_oe,
  input  logic [1:0]    p_dqs_i,
  output logic [2*DW-1:0] p_dq_o,
  output logic [1:0]    p_dq_oe,
  input  logic [2*DW-1:0] p_dq_i
);
  logic [1:0]      rv, dp, src_v, src;
  logic [1:0][1:0] csm;
  logic [1:0]      ovr_mask;

  assign ovr_mask = (ovr_sel == 2'd0) ? 2'b01 : (ovr_sel == 2'd1) ? 2'b10 : 2'b11;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      unique case (mode)
        RM_DIRECT: begin rv[i] = 1'b1; dp[i] = 1'(i);  end
        RM_SWAP:   begin rv[i] = 1'b1; dp[i] = ~1'(i); end
        RM_SHARE0: begin rv[i] = own_v && (own == 1'(i)); dp[i] = 1'b0; end
        default:   begin rv[i] = own_v && (own == 1'(i)); dp[i] = 1'b1; end
      endcase
      csm[i] = ovr_en ? ovr_mask : (dp[i] ? 2'b10 : 2'b01);
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      src_v[p] = 1'b0;
      src[p]   = 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (rv[i] && dp[i] == 1'(p)) begin
          src_v[p] = 1'b1;
          src[p]   = 1'(i);
        end
      end
      p_sck[p]    = src_v[p] & c_sck[src[p]];
      p_dqs_o[p]  = src_v[p] & c_dqs_o[src[p]];
      p_dqs_oe[p] = src_v[p] & c_dqs_oe[src[p]];
      p_dq_oe[p]  = src_v[p] & c_dq_oe[src[p]];
      p_dq_o[p*DW +: DW] = src_v[p] ? c_dq_o[src[p]*DW +: DW] : '0;
      p_cs_n[p] = 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (rv[i] && csm[i][p] && !c_cs_n[i]) p_cs_n[p] = 1'b0;
      end
    end
    for (int i = 0; i < 2; i++) begin
      c_dqs_i[i]         = rv[i] & p_dqs_i[dp[i]];
      c_dq_i[i*DW +: DW] = rv[i] ? p_dq_i[dp[i]*DW +: DW] : '0;
    end
  end

  p_quiet_p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_SHARE0) |-> (p_cs_n[1] && !p_dq_oe[1] && !p_dqs_oe[1] && p_dq_o[2*DW-1:DW] == '0));
  p_quiet_p0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_SHARE1) |-> (p_cs_n[0] && !p_dq_oe[0] && !p_dqs_oe[0] && p_dq_o[DW-1:0] == '0));
  p_swap_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_SWAP) |-> (p_dq_o[DW-1:0] == c_dq_o[2*DW-1:DW] && c_dq_i[DW-1:0] == p_dq_i[2*DW-1:DW]));
endmodule

// File: rtl/opr_dec.sv
module opr_dec #(
  parameter int              AW        = 32,
  parameter logic [AW-1:0]   WIN_BASE  = 32'h6000_0000,
  parameter int              UNIT_LG   = 26,
  parameter int              WIN_UNITS = 4,
  parameter int              SPLIT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [AW-1:0]      addr,
  input  logic [SPLIT_W-1:0] split,
  output logic [1:0]         sel,
  output logic               err
);
  localparam logic [AW:0] SPAN = (AW+1)'(WIN_UNITS) << UNIT_LG;
  localparam logic [SPLIT_W-1:0] UNITS_L = SPLIT_W'(WIN_UNITS);

  logic [AW:0]        off;
  logic [SPLIT_W-1:0] unit_idx, s_eff;
  logic               in_win, hi;

  assign off      = {1'b0, addr} - {1'b0, WIN_BASE};
  assign in_win   = off < SPAN;
  assign unit_idx = off[UNIT_LG +: SPLIT_W];
  assign s_eff    = (split > UNITS_L) ? UNITS_L : split;
  assign hi       = unit_idx >= (UNITS_L - s_eff);

  assign err = valid && !in_win;
  assign sel = (valid && in_win) ? (hi ? 2'b10 : 2'b01) : 2'b00;

  p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !err) |-> $onehot(sel));
  p_miss_nosel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sel == 2'b00));
endmodule

// File: rtl/octal_port_router.sv
module octal_port_router
  import opr_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            AW        = 32,
  parameter logic [AW-1:0] WIN_BASE  = 32'h6000_0000,
  parameter int            UNIT_LG   = 26,
  parameter int            WIN_UNITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            mem_valid,
  input  logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_sel,
  output logic            mem_err,
  input  logic [1:0]      c_req,
  output logic [1:0]      c_gnt,
  input  logic [1:0]      c_sck,
  input  logic [1:0]      c_cs_n,
  input  logic [1:0]      c_dqs_o,
  input  logic [1:0]      c_dqs_oe,
  output logic [1:0]      c_dqs_i,
  input  logic [2*DW-1:0] c_dq_o,
  input  logic [1:0]      c_dq_oe,
  output logic [2*DW-1:0] c_dq_i,
  output logic [1:0]      p_sck,
  output logic [1:0]      p_cs_n,
  output logic [1:0]      p_dqs_o,
  output logic [1:0]      p_dqs_oe,
  input  logic [1:0]      p_dqs_i,
  output logic [2*DW-1:0] p_dq_o,
  output logic [1:0]      p_dq_oe,
  input  logic [2*DW-1:0] p_dq_i
);
  localparam int SPLIT_W = $clog2(WIN_UNITS + 1);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [SPLIT_W-1:0] split_q;
  logic               pend, idle, shared, arb_busy, own_v, own;
  route_mode_e        mode;

  assign mode   = route_mode_e'(ctrl_q[1:0]);
  assign shared = ctrl_q[0];
  assign idle   = !arb_busy && (shared || (&c_cs_n));

  opr_regs #(.SPLIT_W(SPLIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .idle(idle), .ctrl_q(ctrl_q), .split_q(split_q), .pend_o(pend), .rdata(reg_rdata)
  );

  opr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .shared(shared), .hold(pend), .req(c_req),
    .cs_n(c_cs_n), .gap(ctrl_q[GAP_LSB +: GAP_W]), .gnt(c_gnt),
    .own_v(own_v), .own(own), .busy(arb_busy)
  );

  opr_xbar #(.DW(DW)) u_xbar (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ovr_en(ctrl_q[OVR_EN_BIT]),
    .ovr_sel(ctrl_q[OVR_SEL_LSB +: 2]), .own_v(own_v), .own(own),
    .c_sck(c_sck), .c_cs_n(c_cs_n), .c_dqs_o(c_dqs_o), .c_dqs_oe(c_dqs_oe),
    .c_dqs_i(c_dqs_i), .c_dq_o(c_dq_o), .c_dq_oe(c_dq_oe), .c_dq_i(c_dq_i),
    .p_sck(p_sck), .p_cs_n(p_cs_n), .p_dqs_o(p_dqs_o), .p_dqs_oe(p_dqs_oe),
    .p_dqs_i(p_dqs_i), .p_dq_o(p_dq_o), .p_dq_oe(p_dq_oe), .p_dq_i(p_dq_i)
  );

  opr_dec #(.AW(AW), .WIN_BASE(WIN_BASE), .UNIT_LG(UNIT_LG),
            .WIN_UNITS(WIN_UNITS), .SPLIT_W(SPLIT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(mem_valid), .addr(mem_addr),
    .split(split_q), .sel(mem_sel), .err(mem_err)
  );
endmodule

// File: tb/tb_octal_port_router.sv
module tb_octal_port_router;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_valid = 1'b0, mem_err;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_sel, c_gnt, c_dqs_i, p_sck, p_cs_n, p_dqs_o, p_dqs_oe, p_dq_oe;
  logic [1:0]  c_req = 2'b00, c_sck = 2'b01, c_cs_n = 2'b11;
  logic [1:0]  c_dqs_o = 2'b10, c_dqs_oe = 2'b11, c_dq_oe = 2'b11, p_dqs_i = 2'b01;
  logic [15:0] c_dq_o = 16'hB2A1, c_dq_i, p_dq_o, p_dq_i = 16'h5CC5;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  octal_port_router dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_err(mem_err), .c_req(c_req),
    .c_gnt(c_gnt), .c_sck(c_sck), .c_cs_n(c_cs_n), .c_dqs_o(c_dqs_o),
    .c_dqs_oe(c_dqs_oe), .c_dqs_i(c_dqs_i), .c_dq_o(c_dq_o), .c_dq_oe(c_dq_oe),
    .c_dq_i(c_dq_i), .p_sck(p_sck), .p_cs_n(p_cs_n), .p_dqs_o(p_dqs_o),
    .p_dqs_oe(p_dqs_oe), .p_dqs_i(p_dqs_i), .p_dq_o(p_dq_o), .p_dq_oe(p_dq_oe),
    .p_dq_i(p_dq_i)
  );

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(1'b0, d); eq("R1 reset ctrl", d, 0);
    reg_rd(1'b1, d); eq("R1 reset split", d, 0);
    eq("R1 reset grants", c_gnt, 2'b11);
  endtask

  task automatic t_direct;
    @(negedge clk); c_cs_n = 2'b10; #1;
    eq("R1 direct data", p_dq_o, 16'hB2A1);
    eq("R1 direct cs", p_cs_n, 2'b10);
    eq("R1 direct sck", p_sck, 2'b01);
    eq("R1 direct return", c_dq_i, 16'h5CC5);
    eq("R1 direct strobe", {p_dqs_o, c_dqs_i}, {2'b10, 2'b01});
    @(negedge clk); c_cs_n = 2'b11;
  endtask

  task automatic t_swap;
    reg_wr(1'b0, 32'h2); #1;
    eq("R2 swap data", p_dq_o, 16'hA1B2);
    eq("R2 swap sck", p_sck, 2'b10);
    eq("R2 swap return", c_dq_i, 16'hC55C);
    eq("R4 swap grants high", c_gnt, 2'b11);
    c_cs_n = 2'b10; #1;
    eq("R2 swap cs", p_cs_n, 2'b01);
    @(negedge clk); c_cs_n = 2'b11;
  endtask

  task automatic t_share0;
    int n;
    reg_wr(1'b0, 32'h0003_0001);
    @(negedge clk); #1; eq("R4 idle share no grant", c_gnt, 2'b00);
    c_req = 2'b11;
    @(negedge clk); #1;
    eq("R4 tie first to c0", c_gnt, 2'b01);
    eq("R3 share0 data", p_dq_o, 16'h00A1);
    eq("R3 share0 oe", {p_dq_oe, p_dqs_oe}, {2'b01, 2'b01});
    eq("R3 share0 return", c_dq_i, 16'h00C5);
    c_cs_n = 2'b10; #1;
    eq("R3 share0 cs", p_cs_n, 2'b10);
    settle(3); #1;
    eq("R5 grant held during cs", c_gnt, 2'b01);
    c_cs_n = 2'b11;
    n = 0;
    do begin @(negedge clk); #1; if (c_gnt == 2'b00) n++; end
    while (c_gnt == 2'b00 && n < 50);
    eq("R6 gap cycles", n, 4);
    eq("R4 round robin to c1", c_gnt, 2'b10);
    eq("R3 c1 on port0", p_dq_o, 16'h00B2);
    eq("R3 c1 return", c_dq_i, 16'hC500);
    c_cs_n = 2'b01;
    @(negedge clk); c_cs_n = 2'b11;
    settle(6); #1;
    eq("R4 back to c0", c_gnt, 2'b01);
    c_req = 2'b00;
    @(negedge clk); #1;
    eq("R5 release on withdraw", c_gnt, 2'b00);
    settle(6);
  endtask

  task automatic t_share1;
    reg_wr(1'b0, 32'h0000_0003);
    c_req = 2'b10;
    @(negedge clk); #1;
    eq("R3 share1 grant", c_gnt, 2'b10);
    eq("R3 share1 data", p_dq_o, 16'hB200);
    eq("R3 share1 oe", p_dq_oe, 2'b10);
    c_cs_n = 2'b00; #1;
    eq("R3 share1 port0 quiet", p_cs_n, 2'b01);
    @(negedge clk); c_cs_n = 2'b11; c_req = 2'b00;
    settle(4);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    reg_wr(1'b0, 32'h0003_0001);
    c_req = 2'b01;
    @(negedge clk); c_cs_n = 2'b10;
    reg_wr(1'b0, 32'h0);
    reg_rd(1'b0, d); eq("R10 old value while busy", d, 32'h0003_0001);
    eq("R10 grant unchanged", c_gnt, 2'b01);
    c_cs_n = 2'b11;
    settle(2); #1;
    eq("R10 still pending in gap", reg_rdata, 32'h0003_0001);
    settle(10);
    reg_rd(1'b0, d); eq("R10 applied when idle", d, 0);
    eq("R10 new mode grants", c_gnt, 2'b11);
    c_req = 2'b00;
  endtask

  task automatic t_override;
    reg_wr(1'b0, 32'h30);
    c_cs_n = 2'b10; #1;
    eq("R7 sel1 redirect", p_cs_n, 2'b01);
    eq("R7 data kept", p_dq_o, 16'hB2A1);
    @(negedge clk); c_cs_n = 2'b11;
    reg_wr(1'b0, 32'h50);
    c_cs_n = 2'b10; #1;
    eq("R7 sel2 both lines", p_cs_n, 2'b00);
    @(negedge clk); c_cs_n = 2'b11;
    reg_wr(1'b0, 32'h10);
    c_cs_n = 2'b01; #1;
    eq("R7 sel0 line0", p_cs_n, 2'b10);
    @(negedge clk); c_cs_n = 2'b11;
    reg_wr(1'b0, 32'h0);
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] s, input logic e, input string tag);
    @(negedge clk); mem_valid = 1'b1; mem_addr = a; #1;
    eq(tag, {mem_err, mem_sel}, {e, s});
  endtask

  task automatic t_split;
    logic [31:0] d;
    reg_wr(1'b1, 32'h1);
    look(32'h6000_0000, 2'b01, 1'b0, "R8 split1 base");
    look(32'h6BFF_FFFF, 2'b01, 1'b0, "R8 split1 below edge");
    look(32'h6C00_0000, 2'b10, 1'b0, "R8 split1 edge");
    look(32'h6FFF_FFFF, 2'b10, 1'b0, "R8 split1 top");
    look(32'h7000_0000, 2'b00, 1'b1, "R9 above window");
    look(32'h5FFF_FFFF, 2'b00, 1'b1, "R9 below window");
    reg_wr(1'b1, 32'h7);
    reg_rd(1'b1, d); eq("R8 split readback", d, 7);
    look(32'h6000_0000, 2'b10, 1'b0, "R8 clamp all region2");
    reg_wr(1'b1, 32'h0);
    look(32'h6FFF_FFFF, 2'b01, 1'b0, "R8 zero split");
    @(negedge clk); mem_valid = 1'b0; #1;
    eq("R9 invalid quiet", {mem_err, mem_sel}, 3'b000);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset;
    t_direct;
    t_swap;
    t_share0;
    t_share1;
    t_pending;
    t_override;
    t_split;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule